// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

A nine-bit first-in first-out buffer whose write side and read side each run on their own clock. The two clocks may be fully independent or driven from one source. A word enters on a write-clock edge when both write enables are asserted. A word leaves on a read-clock edge when both read enables are asserted and the buffer holds data. A separate output enable floats the data output without disturbing the read path.

Four active-low flags report the fill state. Empty and almost-empty are generated in the read domain. Full and almost-full are generated in the write domain. The pointer of the far side crosses over as a Gray code through two flip-flops. The almost-empty and almost-full thresholds come from two offset registers. Software-side logic can load these registers and read them back through the normal data ports.

The second write-enable pin has two uses, and its level during reset picks one. Held high during reset, it is a plain second write enable. Held low during reset, it becomes a load strobe. While the strobe is low, write-clock edges fill the offset registers and read-clock edges read them back. In both cases the registers are visited in a fixed rotating order.

Top module: `dcfifo_flag`

## Requirements
- R1: After reset, the empty and almost-empty flags are low, the full and almost-full flags are high, and both pointers are at zero.
- R2: A word is stored only on a write-clock edge where `wen1_n` is 0 and `wen2_ld` is 1. The other three combinations of those two pins store nothing.
- R3: Words leave in the order they were written. A read edge loads the oldest unread word into the output register, and the register is visible on `q` after that edge.
- R4: `ef_n` is 0 exactly when the read domain sees no unread words. A read request while `ef_n` is 0 leaves the read pointer and `q` unchanged.
- R5: `ff_n` is 0 exactly when the write domain sees DEPTH unread words. A write request while `ff_n` is 0 is dropped.
- R6: `paf_n` is 0 when the write-domain count is at least DEPTH minus the almost-full offset.
- R7: `pae_n` is 0 when the read-domain count is at most the almost-empty offset.
- R8: The level of `wen2_ld` while `rs_n` is low picks the mode: 1 selects two-enable mode and 0 selects load mode. In load mode, edges with `wen2_ld` at 0 never reach the FIFO array.
- R9: Offset loading works in load mode. With `wen2_ld` at 0 and `wen1_n` at 0, each write edge stores `d` into the next slot. The slot order is almost-empty low, almost-empty high, almost-full low, almost-full high, and then it wraps. Each offset is {high,low} truncated to log2(DEPTH) bits. Reset puts 7 in each low slot and 0 in each high slot, and returns the slot pointer to the first slot.
- R10: Offset readback works in load mode. With `wen2_ld` at 0 and both read enables at 0, each read edge places the next slot on `q`, in the same rotating order as R9, starting from the first slot after reset.
- R11: `q` is high impedance whenever `oe_n` is 1. When `oe_n` is 0, `q` shows the output register.
- R12: With both clocks tied together, `ef_n` stays 0 after the first edge that follows a write into an empty FIFO. It rises after the second such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rs_n | input | 1 | Active-low reset, asynchronous for pointers and flags |
| wen1_n | input | 1 | First write enable, active low |
| wen2_ld | input | 1 | Second write enable (active high) or offset load strobe (active low), chosen at reset |
| d | input | W | Write data, or offset value in load mode |
| ren1_n | input | 1 | First read enable, active low |
| ren2_n | input | 1 | Second read enable, active low |
| oe_n | input | 1 | Output enable, active low |
| q | output | W | Read data or offset readback, high impedance when disabled |
| ef_n | output | 1 | Empty flag, active low, read domain |
| ff_n | output | 1 | Full flag, active low, write domain |
| pae_n | output | 1 | Almost-empty flag, active low, read domain |
| paf_n | output | 1 | Almost-full flag, active low, write domain |

## Verification
The assertions assume three things about the inputs. First, `wen2_ld` holds a steady level over the last clock of reset. Second, offset writes and offset readback never share a cycle. Third, offsets are changed only while the FIFO is idle, because the read domain uses the almost-empty offset without synchronizing it. The stimulus respects all three. It drives every input on the falling edge, holds the reset level for several cycles before release, and spaces loads and readbacks into separate cycles with no FIFO traffic in between. With both clocks tied, the bench fills a 16-word instance one word at a time and then drains it one word at a time. After each step it waits three cycles so both synchronizers settle, and then it compares all four flags with thresholds computed from the occupancy and the loaded offsets.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
   localparam int OFF_SLOTS  = 4;
   localparam int DEF_OFFSET = 7;

   // Rotation order of the offset slots; the load and readback order depends on it.
   typedef enum logic [1:0] {
      SLOT_AE_LO = 2'd0,
      SLOT_AE_HI = 2'd1,
      SLOT_AF_LO = 2'd2,
      SLOT_AF_HI = 2'd3
   } slot_e;

   function automatic slot_e slot_next(slot_e s);
      return slot_e'(s + 2'd1);
   endfunction
endpackage

// File: rtl/fifo_dp_ram.sv
`timescale 1ns/1ps
module fifo_dp_ram #(
   parameter int W  = 9,
   parameter int AW = 6
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   localparam int WORDS = 1 << AW;

   logic [W-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_ptr_sync.sv
`timescale 1ns/1ps
module fifo_ptr_sync #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] gray_in,
   output logic [N-1:0] bin_out
);
   logic [N-1:0] meta_q, sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= gray_in;
         sync_q <= meta_q;
      end
   end

   always_comb begin
      for (int i = 0; i < N; i++) bin_out[i] = ^(sync_q >> i);
   end
endmodule

// File: rtl/fifo_offset_bank.sv
`timescale 1ns/1ps
module fifo_offset_bank
   import dcfifo_pkg::*;
#(
   parameter int W  = 9,
   parameter int AW = 6
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          ld_stb,
   input  logic [W-1:0]  ld_data,
   input  logic          rb_stb,
   output logic [W-1:0]  rb_data,
   output logic [AW-1:0] ae_off,
   output logic [AW-1:0] af_off
);
   slot_e        wslot, rslot;
   logic [W-1:0] slots [OFF_SLOTS];

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n)      wslot <= SLOT_AE_LO;
      else if (ld_stb) wslot <= slot_next(wslot);
   end

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n)      rslot <= SLOT_AE_LO;
      else if (rb_stb) rslot <= slot_next(rslot);
   end

   for (genvar s = 0; s < OFF_SLOTS; s++) begin : g_slot
      localparam logic [W-1:0] RST_VAL =
         (s % 2 == 0) ? W'(DEF_OFFSET) : W'(DEF_OFFSET >> W);
      logic [W-1:0] val_q;
      always_ff @(posedge wclk or negedge rst_n) begin
         if (!rst_n)                              val_q <= RST_VAL;
         else if (ld_stb && wslot == slot_e'(s))  val_q <= ld_data;
      end
      assign slots[s] = val_q;
   end

   assign rb_data = slots[rslot];
   assign ae_off  = AW'({slots[SLOT_AE_HI], slots[SLOT_AE_LO]});
   assign af_off  = AW'({slots[SLOT_AF_HI], slots[SLOT_AF_LO]});
endmodule

// File: rtl/dcfifo_flag.sv
`timescale 1ns/1ps
module dcfifo_flag
   import dcfifo_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int W     = 9
) (
   input  logic         wclk,
   input  logic         rclk,
   input  logic         rs_n,
   input  logic         wen1_n,
   input  logic         wen2_ld,
   input  logic [W-1:0] d,
   input  logic         ren1_n,
   input  logic         ren2_n,
   input  logic         oe_n,
   output logic [W-1:0] q,
   output logic         ef_n,
   output logic         ff_n,
   output logic         pae_n,
   output logic         paf_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;
   localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
   localparam logic [PW:0]   DEPTH_X = (PW+1)'(DEPTH);

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (AW > 2 * W) begin : g_bad_width
      $error("offset slots too narrow for DEPTH");
   end

   // Mode is sampled on write-clock edges while reset is held.
   logic load_mode;
   always_ff @(posedge wclk) begin
      if (!rs_n) load_mode <= ~wen2_ld;
   end

   // ---------------- write domain ----------------
   logic [PW-1:0] wbin, wgray, wnext, rbin_w, wcount;
   logic [AW-1:0] ae_off, af_off;
   logic          wr_en, ld_stb;

   assign wr_en  = !wen1_n && wen2_ld && ff_n;
   assign ld_stb = load_mode && !wen2_ld && !wen1_n;
   assign wnext  = wbin + PW'(1);

   always_ff @(posedge wclk or negedge rs_n) begin
      if (!rs_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_en) begin
         wbin  <= wnext;
         wgray <= wnext ^ (wnext >> 1);
      end
   end

   logic [PW-1:0] rbin, rgray, rnext, wbin_r, rcount;

   fifo_ptr_sync #(.N(PW)) u_r2w (
      .clk(wclk), .rst_n(rs_n), .gray_in(rgray), .bin_out(rbin_w)
   );

   assign wcount = wbin - rbin_w;

   always_comb begin
      ff_n  = (wcount != DEPTH_P);
      paf_n = !(({1'b0, wcount} + (PW+1)'(af_off)) >= DEPTH_X);
   end

   // ---------------- read domain ----------------
   logic          rd_en, rb_stb;
   logic [W-1:0]  ram_q, rb_data, q_reg;

   assign rd_en  = !ren1_n && !ren2_n && ef_n && (!load_mode || wen2_ld);
   assign rb_stb = load_mode && !wen2_ld && !ren1_n && !ren2_n;
   assign rnext  = rbin + PW'(1);

   always_ff @(posedge rclk or negedge rs_n) begin
      if (!rs_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_en) begin
         rbin  <= rnext;
         rgray <= rnext ^ (rnext >> 1);
      end
   end

   fifo_ptr_sync #(.N(PW)) u_w2r (
      .clk(rclk), .rst_n(rs_n), .gray_in(wgray), .bin_out(wbin_r)
   );

   assign rcount = wbin_r - rbin;

   always_comb begin
      ef_n  = (rcount != '0);
      pae_n = !(rcount <= PW'(ae_off));
   end

   always_ff @(posedge rclk or negedge rs_n) begin
      if (!rs_n)       q_reg <= '0;
      else if (rb_stb) q_reg <= rb_data;
      else if (rd_en)  q_reg <= ram_q;
   end

   assign q = oe_n ? 'z : q_reg;

   // ---------------- storage ----------------
   fifo_dp_ram #(.W(W), .AW(AW)) u_ram (
      .wclk(wclk), .we(wr_en), .waddr(wbin[AW-1:0]), .wdata(d),
      .raddr(rbin[AW-1:0]), .rdata(ram_q)
   );

   fifo_offset_bank #(.W(W), .AW(AW)) u_off (
      .wclk(wclk), .rclk(rclk), .rst_n(rs_n),
      .ld_stb(ld_stb), .ld_data(d), .rb_stb(rb_stb), .rb_data(rb_data),
      .ae_off(ae_off), .af_off(af_off)
   );

   // ---------------- assertions ----------------
   assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!rs_n)
      wcount <= DEPTH_P);

   assert_full_blocks_R5: assert property (@(posedge wclk) disable iff (!rs_n)
      (!ff_n && !wen1_n && wen2_ld) |=> (wbin == $past(wbin)));

   assert_no_underflow_R4: assert property (@(posedge rclk) disable iff (!rs_n)
      rcount <= DEPTH_P);

   assert_empty_blocks_R4: assert property (@(posedge rclk) disable iff (!rs_n)
      (!ef_n) |=> (rbin == $past(rbin)));

   assert_gray_step_R3: assert property (@(posedge wclk) disable iff (!rs_n)
      1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

   assert_mode_hold_R8: assert property (@(posedge wclk) disable iff (!rs_n)
      1'b1 |=> $stable(load_mode));
endmodule

// File: tb/sim_dcfifo_flag.sv
`timescale 1ns/1ps
module sim_dcfifo_flag;
   localparam int D = 16;

   logic       clk = 1'b0;
   logic       rs_n = 1'b0, wen1_n = 1'b1, wen2_ld = 1'b1;
   logic       ren1_n = 1'b1, ren2_n = 1'b1, oe_n = 1'b0;
   logic [8:0] d = '0;
   wire  [8:0] q;
   wire        ef_n, ff_n, pae_n, paf_n;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   dcfifo_flag #(.DEPTH(D), .W(9)) u0 (
      .wclk(clk), .rclk(clk), .rs_n(rs_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
      .d(d), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .q(q),
      .ef_n(ef_n), .ff_n(ff_n), .pae_n(pae_n), .paf_n(paf_n)
   );

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [8:0] pat(int k);
      return 9'((k * 37 + 11) & 9'h1FF);
   endfunction

   task automatic do_reset(logic lvl);
      rs_n = 1'b0; wen2_ld = lvl; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
      tick(3);
      rs_n = 1'b1;
      tick(1);
      wen2_ld = 1'b1;
   endtask

   task automatic put(logic [8:0] v);
      wen1_n = 1'b0; d = v;
      tick(1);
      wen1_n = 1'b1;
   endtask

   task automatic take();
      ren1_n = 1'b0; ren2_n = 1'b0;
      tick(1);
      ren1_n = 1'b1; ren2_n = 1'b1;
   endtask

   task automatic load_off(logic [8:0] v);
      wen2_ld = 1'b0; wen1_n = 1'b0; d = v;
      tick(1);
      wen1_n = 1'b1; wen2_ld = 1'b1;
   endtask

   task automatic readback(int exp);
      wen2_ld = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
      tick(1);
      ren1_n = 1'b1; ren2_n = 1'b1; wen2_ld = 1'b1;
      chk(q === 9'(exp), "R10 offset readback", int'(q), exp);
   endtask

   task automatic flags(int cnt, int ae, int af);
      chk(ef_n  == (cnt != 0),       "R4 ef_n",  int'(ef_n),  int'(cnt != 0));
      chk(ff_n  == (cnt != D),       "R5 ff_n",  int'(ff_n),  int'(cnt != D));
      chk(pae_n == !(cnt <= ae),     "R7 pae_n", int'(pae_n), int'(!(cnt <= ae)));
      chk(paf_n == !(cnt >= D - af), "R6 paf_n", int'(paf_n), int'(!(cnt >= D - af)));
   endtask

   task automatic sweep(int ae, int af, int base);
      for (int k = 1; k <= D; k++) begin
         put(pat(k + base));
         tick(3);
         flags(k, ae, af);
      end
      put(9'h155);                       // R5: dropped while full
      tick(3);
      chk(ff_n == 1'b0, "R5 still full", int'(ff_n), 0);
      for (int k = 1; k <= D; k++) begin
         take();
         chk(q === pat(k + base), "R3 order", int'(q), int'(pat(k + base)));
         tick(3);
         flags(D - k, ae, af);
      end
      take();                            // R5: extra word never stored
      chk(ef_n == 1'b0, "R5 extra word absent", int'(ef_n), 0);
      chk(q === pat(D + base), "R4 q held when empty", int'(q), int'(pat(D + base)));
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // two-enable mode (R8)
      do_reset(1'b1);
      flags(0, 7, 7);                    // R1
      chk(q === 9'h000, "R1 q reset", int'(q), 0);

      // R12 latency and R3 first word
      put(9'h0A5);
      chk(ef_n == 1'b0, "R12 ef after edge1", int'(ef_n), 0);
      tick(1);
      chk(ef_n == 1'b0, "R12 ef after edge2", int'(ef_n), 0);
      tick(1);
      chk(ef_n == 1'b1, "R12 ef rises", int'(ef_n), 1);
      take();
      chk(q === 9'h0A5, "R3 first word", int'(q), 'h0A5);
      chk(ef_n == 1'b0, "R4 empty after read", int'(ef_n), 0);
      take();
      chk(q === 9'h0A5, "R4 read blocked", int'(q), 'h0A5);

      // R2 gated combinations
      d = 9'h1FF;
      wen1_n = 1'b1; wen2_ld = 1'b1; tick(1);
      wen1_n = 1'b0; wen2_ld = 1'b0; tick(1);
      wen1_n = 1'b1; wen2_ld = 1'b0; tick(1);
      wen1_n = 1'b1; wen2_ld = 1'b1;
      tick(3);
      chk(ef_n == 1'b0, "R2 no write stored", int'(ef_n), 0);
      tick(3);
      flags(0, 7, 7);

      sweep(7, 7, 0);

      // R11 output enable
      oe_n = 1'b1;
      #1;
      chk(q === 9'bz, "R11 hi-z", int'(q), 0);
      oe_n = 1'b0;
      #1;
      chk(q === pat(D), "R11 driven", int'(q), int'(pat(D)));

      // load mode (R8, R9, R10)
      do_reset(1'b0);
      flags(0, 7, 7);                    // R1
      readback(7); readback(0); readback(7); readback(0);   // R9 defaults
      load_off(9'd3); load_off(9'd0); load_off(9'd2); load_off(9'd0);
      load_off(9'd4);                    // R9 wrap to almost-empty low
      tick(3);
      chk(ef_n == 1'b0, "R8 load edges not in FIFO", int'(ef_n), 0);
      readback(4); readback(0); readback(2); readback(0);
      sweep(4, 2, 50);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule